// File: doc/BRIEF.md
# Lookup-Driven Bit-Slice ALU

This block is a combinational integer ALU of parameterised width, assembled from one repeated bit slice. Every slice holds three tiny programmable function units. Each unit is a four-entry lookup indexed by two input bits. The first unit forms a propagate bit from the operand bits. The second forms a generate bit from the same operand bits. The third forms the result bit from the propagate bit and the slice's incoming carry. A ripple chain passes the carry from slice to slice: a slice forwards its incoming carry when its propagate bit is 1, and its generate bit otherwise.

An opcode decoder at the top turns a 5-bit operation code into three 4-bit lookup codes and a chain carry-in. A new operation therefore needs one decoder row, with no extra datapath hardware. Bit 3 of each lookup code is the output for inputs (1,1) and bit 0 is the output for (0,0). The first input of a unit is the upper select bit: operand `a` for the propagate and generate units, and the propagate bit for the result unit. The ALU has three outputs: the result, a carry-out and a zero flag.

Top module: `bsalu`

## Requirements
- R1: Opcode 0 gives `{cout,y}` = a+b. Opcode 1 gives `{cout,y}` = a+b+cin.
- R2: Opcode 2 gives y = a−b. Opcode 3 gives y = a−b−cin. In both, `cout` is 1 when no borrow occurs, that is the carry of a + ~b + 1 for opcode 2 and of a + ~b + (1−cin) for opcode 3.
- R3: Opcode 4 gives y = b−a and opcode 5 gives y = b−a−cin. The carry-out follows the convention of R2, with a and b exchanged.
- R4: Opcode 6 gives y = −a and opcode 7 gives y = −b. The carry-out is that of ~x+1, so it is 1 only when the operand is 0.
- R5: Opcodes 8 and 9 give a+1 and b+1. Opcodes 10 and 11 give a−1 and b−1, formed as x + all-ones. `cout` is the carry of that sum.
- R6: Opcodes 12 to 18 give a&b, a|b, a^b, ~a, ~b, a and b, in that order. For all of them `cout` is 0.
- R7: Opcode 19 and every unused opcode (20 to 31) give y = 0 and `cout` = 0.
- R8: `zero` is 1 exactly when every bit of y is 0.
- R9: `cin` has no effect on any opcode other than 1, 3 and 5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| cin | input | 1 | Carry or borrow input for opcodes 1, 3 and 5 |
| op | input | 5 | Operation code |
| y | output | WIDTH | Result |
| cout | output | 1 | Carry-out (no-borrow for subtraction), 0 for non-arithmetic ops |
| zero | output | 1 | High when y is all zeros |

## Verification
The bench builds two copies of the ALU. The first has WIDTH=4, which makes every opcode, operand pair and carry-in value reachable, including all 32 opcode values. This sweep covers each ripple pattern, including a carry running through every slice and borrows that wrap around. The second copy uses the default WIDTH=8. It is driven with seeded random operands and with directed edge values such as all-ones plus one, zero minus one and negation of the most negative value. This checks that the slice chain and decoder scale correctly.

// File: rtl/bsalu.sv
module bsalu #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  input  logic [4:0]       op,
  output logic [WIDTH-1:0] y,
  output logic             cout,
  output logic             zero
);
  localparam logic [3:0] F_ZERO = 4'b0000;
  localparam logic [3:0] F_AND  = 4'b1000;
  localparam logic [3:0] F_OR   = 4'b1110;
  localparam logic [3:0] F_XOR  = 4'b0110;
  localparam logic [3:0] F_XNOR = 4'b1001;
  localparam logic [3:0] F_X    = 4'b1100;
  localparam logic [3:0] F_Y    = 4'b1010;
  localparam logic [3:0] F_NX   = 4'b0011;
  localparam logic [3:0] F_NY   = 4'b0101;
  localparam logic [3:0] F_XNY  = 4'b0100;
  localparam logic [3:0] F_NXY  = 4'b0010;

  logic [3:0] pc, kc, rc;
  logic       c0, arith;
  logic [WIDTH-1:0] p, k;
  logic [WIDTH:0]   c;

  always_comb begin
    pc = F_ZERO; kc = F_ZERO; rc = F_XOR; c0 = 1'b0; arith = 1'b1;
    case (op)
      5'd0:  begin pc = F_XOR;  kc = F_AND; end
      5'd1:  begin pc = F_XOR;  kc = F_AND; c0 = cin; end
      5'd2:  begin pc = F_XNOR; kc = F_XNY; c0 = 1'b1; end
      5'd3:  begin pc = F_XNOR; kc = F_XNY; c0 = ~cin; end
      5'd4:  begin pc = F_XNOR; kc = F_NXY; c0 = 1'b1; end
      5'd5:  begin pc = F_XNOR; kc = F_NXY; c0 = ~cin; end
      5'd6:  begin pc = F_NX; c0 = 1'b1; end
      5'd7:  begin pc = F_NY; c0 = 1'b1; end
      5'd8:  begin pc = F_X;  c0 = 1'b1; end
      5'd9:  begin pc = F_Y;  c0 = 1'b1; end
      5'd10: begin pc = F_NX; kc = F_X; end
      5'd11: begin pc = F_NY; kc = F_Y; end
      5'd12: begin pc = F_AND;  rc = F_X; arith = 1'b0; end
      5'd13: begin pc = F_OR;   rc = F_X; arith = 1'b0; end
      5'd14: begin pc = F_XOR;  rc = F_X; arith = 1'b0; end
      5'd15: begin pc = F_NX;   rc = F_X; arith = 1'b0; end
      5'd16: begin pc = F_NY;   rc = F_X; arith = 1'b0; end
      5'd17: begin pc = F_X;    rc = F_X; arith = 1'b0; end
      5'd18: begin pc = F_Y;    rc = F_X; arith = 1'b0; end
      default: begin rc = F_ZERO; arith = 1'b0; end
    endcase
  end

  assign c[0] = c0;

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    assign p[i]   = pc[{a[i], b[i]}];
    assign k[i]   = kc[{a[i], b[i]}];
    assign c[i+1] = p[i] ? c[i] : k[i];
    assign y[i]   = rc[{p[i], c[i]}];
  end

  assign cout = arith & c[WIDTH];
  assign zero = ~|y;
endmodule

// File: rtl/bsalu_chk.sv
module bsalu_chk #(
  parameter int WIDTH = 8
) (
  input logic [WIDTH-1:0] a,
  input logic [WIDTH-1:0] b,
  input logic             cin,
  input logic [4:0]       op,
  input logic [WIDTH-1:0] y,
  input logic             cout,
  input logic             zero
);
  logic [WIDTH:0] add_ref;
  logic [WIDTH-1:0] sub_ref;
  assign add_ref = {1'b0, a} + {1'b0, b};
  assign sub_ref = a - b;

  always_comb begin
    if (op == 5'd0)
      a_r1_add_sum: assert ({cout, y} == add_ref);
    if (op == 5'd2)
      a_r2_sub_diff: assert (y == sub_ref);
    if (op >= 5'd12 && op <= 5'd18)
      a_r6_logic_no_carry: assert (!cout);
    if (op >= 5'd19)
      a_r7_idle_zero: assert (zero && !cout);
    if (op == 5'd14 && a == b)
      a_r8_xor_equal_zero: assert (zero);
    if (op == 5'd15)
      a_r6_not_a: assert (y == ~a);
    if (cin == 1'b0 && op == 5'd1)
      a_r1_adc_no_cin: assert ({cout, y} == add_ref);
  end
endmodule

bind bsalu bsalu_chk #(.WIDTH(WIDTH)) u_chk (
  .a(a), .b(b), .cin(cin), .op(op), .y(y), .cout(cout), .zero(zero)
);

// File: tb/tb_bsalu.sv
module tb_bsalu;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;

  logic [3:0] a4, b4, y4;
  logic [7:0] a8, b8, y8;
  logic       cin4, cin8, cout4, cout8, z4, z8;
  logic [4:0] op4, op8;

  bsalu #(.WIDTH(4)) d4 (.a(a4), .b(b4), .cin(cin4), .op(op4), .y(y4), .cout(cout4), .zero(z4));
  bsalu #(.WIDTH(8)) dut (.a(a8), .b(b8), .cin(cin8), .op(op8), .y(y8), .cout(cout8), .zero(z8));

  function automatic logic [31:0] ref_calc(int w, int op, logic [31:0] a, logic [31:0] b, logic cin);
    logic [31:0] m, na, nb, ci, nci, s;
    m = (32'd1 << w) - 32'd1;
    na = ~a & m; nb = ~b & m;
    ci = {31'd0, cin}; nci = {31'd0, ~cin};
    case (op)
      0: s = a + b;
      1: s = a + b + ci;
      2: s = a + nb + 1;
      3: s = a + nb + nci;
      4: s = b + na + 1;
      5: s = b + na + nci;
      6: s = na + 1;
      7: s = nb + 1;
      8: s = a + 1;
      9: s = b + 1;
      10: s = a + m;
      11: s = b + m;
      12: s = a & b;
      13: s = a | b;
      14: s = a ^ b;
      15: s = na;
      16: s = nb;
      17: s = a;
      18: s = b;
      default: s = 0;
    endcase
    if (op >= 12) s = s & m;
    return s & ((m << 1) | 32'd1);
  endfunction

  function automatic string tag_of(int op, logic cin);
    if (cin && op != 1 && op != 3 && op != 5) return "R9";
    if (op <= 1) return "R1";
    if (op <= 3) return "R2";
    if (op <= 5) return "R3";
    if (op <= 7) return "R4";
    if (op <= 11) return "R5";
    if (op <= 18) return "R6";
    return "R7";
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run8(int op, logic [7:0] a, logic [7:0] b, logic cin);
    logic [31:0] r;
    @(posedge clk);
    op8 = op[4:0]; a8 = a; b8 = b; cin8 = cin;
    @(negedge clk);
    r = ref_calc(8, op, {24'd0, a}, {24'd0, b}, cin);
    chk(tag_of(op, cin), {23'd0, cout8, y8}, r & 32'h1ff);
    chk("R8", {31'd0, z8}, {31'd0, (r[7:0] == 8'd0)});
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'd1234));
    a4 = 0; b4 = 0; cin4 = 0; op4 = 5'd19;
    a8 = 8'h5a; b8 = 8'ha5; cin8 = 1; op8 = 5'd19;
    @(negedge clk);
    chk("R7", {23'd0, cout8, y8}, 32'd0);
    chk("R8", {31'd0, z8}, 32'd1);

    for (int op = 0; op < 32; op++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++)
          for (int c = 0; c < 2; c++) begin
            @(posedge clk);
            op4 = op[4:0]; a4 = a[3:0]; b4 = b[3:0]; cin4 = c[0];
            @(negedge clk);
            r = ref_calc(4, op, a, b, c[0]);
            chk(tag_of(op, c[0]), {27'd0, cout4, y4}, r & 32'h1f);
            chk("R8", {31'd0, z4}, {31'd0, (r[3:0] == 4'd0)});
          end

    run8(0, 8'hff, 8'h01, 1'b0);
    run8(1, 8'hff, 8'h00, 1'b1);
    run8(2, 8'h00, 8'h01, 1'b0);
    run8(3, 8'h00, 8'h00, 1'b1);
    run8(4, 8'h10, 8'h0f, 1'b0);
    run8(6, 8'h00, 8'h00, 1'b0);
    run8(6, 8'h80, 8'h00, 1'b0);
    run8(8, 8'hff, 8'h00, 1'b0);
    run8(10, 8'h00, 8'h00, 1'b0);
    run8(11, 8'h00, 8'h01, 1'b0);
    run8(14, 8'h3c, 8'h3c, 1'b1);

    for (int n = 0; n < 3000; n++)
      run8(int'($urandom_range(31, 0)), 8'($urandom), 8'($urandom), 1'($urandom));

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule